// File: doc/BRIEF.md
# Guest-Mode Exit Decision Unit

This unit sits next to the instruction decoder of a processor core that can run software in a guest mode under a monitor. Each cycle the decoder may offer one decoded event: an instruction class, an exception vector, an I/O port access or a move to or from a control register. Alongside it come two level inputs, the external interrupt request and the guest's interrupt-enable flag. The unit combines these with a small set of control registers. Those registers hold the per-instruction exit enables, a 32-bit exception bitmap and two interrupt control bits. From all of this it decides whether the monitor must take over.

When an exit is decided, the unit latches a 16-bit reason code and a 32-bit qualification word and raises `exit_valid`. It holds all three until the monitor acknowledges. I/O accesses are checked against a per-port bitmap held outside the unit and read through a synchronous lookup port with one cycle of latency. During that lookup the unit lowers `ev_ready`, so the decoder cannot offer a second event. Control registers are written through a plain write port. Reset clears every control bit, so after reset only the unconditional exits remain.

Top module: `vm_exit_unit`

## Requirements
- R1: With `guest_mode` low, `exit_valid` never rises, and events offered in that mode are discarded.
- R2: In guest mode, CPUID, RDMSR and WRMSR instruction events, and a control-register move that reads CR3, always exit, even with every control bit clear.
- R3: HLT, INVLPG, MWAIT, RDPMC, RDTSC, debug-register moves and CR8 moves exit only when their own enable bit is set. The enable bits in control word 0 are: HLT bit 0, INVLPG bit 1, CR8 bit 2, debug-register move bit 3, MWAIT bit 4, RDPMC bit 5, RDTSC bit 6. The instruction class codes on `ev_cls` are: CPUID 1, RDMSR 2, WRMSR 3, HLT 4, INVLPG 5, MWAIT 6, RDPMC 7, RDTSC 8, debug-register move 9. Code 0 never exits.
- R4: The exception bitmap is control word 1. An exception event (`ev_kind` 2) with vector n exits only if bit n is set. Its qualification is the vector, zero-extended.
- R5: When bit 0 of control word 2 is set, a high `ext_irq` in guest mode causes an exit whatever the value of `guest_if`.
- R6: When bit 1 of control word 2 is set, an exit is taken in any guest-mode cycle in which `guest_if` is high and no higher-priority cause is present.
- R7: An I/O event (`ev_kind` 3) drives `iobm_rd_en` and `iobm_rd_addr` in the same cycle. `ev_ready` is low in the following cycle, and `exit_valid` rises one cycle later than it would for a non-I/O event, only if the returned bit is 1. The qualification is the port number, zero-extended.
- R8: A control-register move (`ev_kind` 4) that exits reports a qualification with the CR number in bits [3:0], bit 4 set for a read from the CR, the GPR index in bits [11:8], and all other bits zero.
- R9: When causes coincide, the priority from highest to lowest is exception, external interrupt, instruction/I/O/CR move, interrupt window.
- R10: `exit_valid`, `exit_reason` and `exit_qual` stay unchanged until the first cycle in which `exit_ack` is high. `exit_valid` is low in the cycle after that. `ev_ready` is low while `exit_valid` is high.
- R11: Synchronous reset clears `exit_valid`, any pending I/O lookup and all control words to zero.
- R12: The reason codes are: exception 0, external interrupt 1, interrupt window 7, CPUID 10, HLT 12, INVLPG 14, RDPMC 15, RDTSC 16, CR access 28, debug-register access 29, I/O 30, RDMSR 31, WRMSR 32, MWAIT 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guest_mode | input | 1 | High while guest software runs |
| ctl_we | input | 1 | Control register write strobe |
| ctl_addr | input | 2 | Control word select: 0 enables, 1 exception bitmap, 2 interrupt controls |
| ctl_wdata | input | 32 | Control write data |
| ev_valid | input | 1 | Decoder offers an event |
| ev_ready | output | 1 | Unit can accept an event this cycle |
| ev_kind | input | 3 | 0 none, 1 instruction, 2 exception, 3 I/O, 4 CR move |
| ev_cls | input | 4 | Instruction class code |
| ev_vector | input | 5 | Exception vector |
| ev_port | input | 16 | I/O port number |
| ev_cr_num | input | 4 | Control register number of a CR move |
| ev_cr_read | input | 1 | CR move reads the CR |
| ev_gpr | input | 4 | General-purpose register index of a CR move |
| ext_irq | input | 1 | External interrupt request level |
| guest_if | input | 1 | Guest interrupt-enable flag |
| iobm_rd_en | output | 1 | I/O bitmap lookup strobe |
| iobm_rd_addr | output | 16 | I/O bitmap lookup port number |
| iobm_rd_bit | input | 1 | Bitmap bit, valid the cycle after the strobe |
| exit_valid | output | 1 | An exit is pending |
| exit_reason | output | 16 | Exit reason code |
| exit_qual | output | 32 | Exit qualification |
| exit_ack | input | 1 | Monitor takes the pending exit |

## Verification
Several properties are checked on every cycle. Root mode never raises an exit. A pending exit holds steady until acknowledged and drops right after. A bitmap lookup always makes the unit busy in the next cycle and never stays pending for two. CR-access and exception qualifications never carry stray bits. Reset leaves the control words at zero. Other behaviour shows only in the bench's scenarios, compared cycle by cycle with a behavioural model. That covers which cause wins when several coincide, the exact reason codes, each enable bit acting on its own instruction, single bitmap bits selecting their vectors or ports, and events offered while busy being dropped.

// File: rtl/vm_exit_pkg.sv
package vm_exit_pkg;

    localparam int CTL_W   = 32;
    localparam int QUAL_W  = 32;
    localparam int VEC_W   = 5;
    localparam int N_EN    = 7;

    // control word select
    localparam logic [1:0] CA_ENABLES = 2'd0;
    localparam logic [1:0] CA_EXC_MAP = 2'd1;
    localparam logic [1:0] CA_INT_CTL = 2'd2;

    // enable bit positions in control word 0
    localparam int EN_HLT    = 0;
    localparam int EN_INVLPG = 1;
    localparam int EN_CR8    = 2;
    localparam int EN_MOVDR  = 3;
    localparam int EN_MWAIT  = 4;
    localparam int EN_RDPMC  = 5;
    localparam int EN_RDTSC  = 6;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_INSTR = 3'd1,
        EV_EXC   = 3'd2,
        EV_IO    = 3'd3,
        EV_CRMOV = 3'd4
    } ev_kind_e;

    typedef enum logic [3:0] {
        IC_NOP    = 4'd0,
        IC_CPUID  = 4'd1,
        IC_RDMSR  = 4'd2,
        IC_WRMSR  = 4'd3,
        IC_HLT    = 4'd4,
        IC_INVLPG = 4'd5,
        IC_MWAIT  = 4'd6,
        IC_RDPMC  = 4'd7,
        IC_RDTSC  = 4'd8,
        IC_MOVDR  = 4'd9
    } instr_cls_e;

    typedef enum logic [15:0] {
        RS_EXCEPTION  = 16'd0,
        RS_EXT_INT    = 16'd1,
        RS_INT_WINDOW = 16'd7,
        RS_CPUID      = 16'd10,
        RS_HLT        = 16'd12,
        RS_INVLPG     = 16'd14,
        RS_RDPMC      = 16'd15,
        RS_RDTSC      = 16'd16,
        RS_CR_ACCESS  = 16'd28,
        RS_DR_ACCESS  = 16'd29,
        RS_IO         = 16'd30,
        RS_RDMSR      = 16'd31,
        RS_WRMSR      = 16'd32,
        RS_MWAIT      = 16'd36
    } reason_e;

    // one candidate exit cause
    typedef struct packed {
        logic              hit;
        reason_e           reason;
        logic [QUAL_W-1:0] qual;
    } exit_cand_t;

    // priority slots, lowest index wins
    localparam int SLOT_EXC   = 0;
    localparam int SLOT_EXT   = 1;
    localparam int SLOT_INSTR = 2;
    localparam int SLOT_WIN   = 3;
    localparam int N_SLOTS    = 4;

    function automatic exit_cand_t no_cand();
        return '{hit: 1'b0, reason: RS_EXCEPTION, qual: '0};
    endfunction

    function automatic exit_cand_t mk_cand(logic h, reason_e r, logic [QUAL_W-1:0] q);
        return '{hit: h, reason: r, qual: q};
    endfunction

    function automatic logic [QUAL_W-1:0] cr_qual(logic [3:0] crn, logic rd, logic [3:0] gpr);
        return {20'd0, gpr, 3'd0, rd, crn};
    endfunction

endpackage

// File: rtl/vm_exit_ctl_regs.sv
module vm_exit_ctl_regs
    import vm_exit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CTL_W-1:0] wdata,
    output logic [N_EN-1:0]  instr_en,
    output logic [31:0]      exc_bitmap,
    output logic             extint_en,
    output logic             window_en
);

    logic unused_wbits;
    assign unused_wbits = ^wdata[CTL_W-1:N_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_en   <= '0;
            exc_bitmap <= '0;
            extint_en  <= 1'b0;
            window_en  <= 1'b0;
        end else if (we) begin
            unique case (addr)
                CA_ENABLES: instr_en   <= wdata[N_EN-1:0];
                CA_EXC_MAP: exc_bitmap <= wdata[31:0];
                CA_INT_CTL: begin
                    extint_en <= wdata[0];
                    window_en <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    p_reset_zero_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (instr_en == '0 && exc_bitmap == '0 && !extint_en && !window_en))
        else $error("R11: controls not cleared by reset");

endmodule

// File: rtl/vm_exit_io_stage.sv
module vm_exit_io_stage #(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PORT_W-1:0] port,
    input  logic              guest,
    input  logic              rd_bit,
    output logic              rd_en,
    output logic [PORT_W-1:0] rd_addr,
    output logic              pend,
    output logic [PORT_W-1:0] port_q,
    output logic              hit
);

    assign rd_en   = start;
    assign rd_addr = port;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            port_q <= '0;
        end else begin
            pend <= start;
            if (start) port_q <= port;
        end
    end

    // the bitmap bit arrives exactly while the request is pending
    assign hit = pend & rd_bit & guest;

    p_single_pending_r7: assert property (@(posedge clk) disable iff (rst)
        pend |=> !pend)
        else $error("R7: second I/O lookup accepted while busy");

endmodule

// File: rtl/vm_exit_classify.sv
module vm_exit_classify
    import vm_exit_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              take,
    input  logic [2:0]        ev_kind,
    input  logic [3:0]        ev_cls,
    input  logic [VEC_W-1:0]  ev_vector,
    input  logic [3:0]        ev_cr_num,
    input  logic              ev_cr_read,
    input  logic [3:0]        ev_gpr,
    input  logic              ext_irq,
    input  logic              guest_if,
    input  logic              io_hit,
    input  logic [PORT_W-1:0] io_port,
    input  logic [N_EN-1:0]   instr_en,
    input  logic [31:0]       exc_bitmap,
    input  logic              extint_en,
    input  logic              window_en,
    output exit_cand_t        win
);

    exit_cand_t slot [N_SLOTS];
    exit_cand_t instr_c;
    exit_cand_t cr_c;

    // instruction-class decode
    always_comb begin
        instr_c = no_cand();
        if (take && ev_kind == EV_INSTR) begin
            unique case (instr_cls_e'(ev_cls))
                IC_CPUID:  instr_c = mk_cand(1'b1, RS_CPUID, '0);
                IC_RDMSR:  instr_c = mk_cand(1'b1, RS_RDMSR, '0);
                IC_WRMSR:  instr_c = mk_cand(1'b1, RS_WRMSR, '0);
                IC_HLT:    instr_c = mk_cand(instr_en[EN_HLT],    RS_HLT,       '0);
                IC_INVLPG: instr_c = mk_cand(instr_en[EN_INVLPG], RS_INVLPG,    '0);
                IC_MWAIT:  instr_c = mk_cand(instr_en[EN_MWAIT],  RS_MWAIT,     '0);
                IC_RDPMC:  instr_c = mk_cand(instr_en[EN_RDPMC],  RS_RDPMC,     '0);
                IC_RDTSC:  instr_c = mk_cand(instr_en[EN_RDTSC],  RS_RDTSC,     '0);
                IC_MOVDR:  instr_c = mk_cand(instr_en[EN_MOVDR],  RS_DR_ACCESS, '0);
                default:   instr_c = no_cand();
            endcase
        end
    end

    // control-register move decode
    always_comb begin
        cr_c = no_cand();
        if (take && ev_kind == EV_CRMOV) begin
            cr_c.reason = RS_CR_ACCESS;
            cr_c.qual   = cr_qual(ev_cr_num, ev_cr_read, ev_gpr);
            cr_c.hit    = (ev_cr_num == 4'd3 && ev_cr_read) ||
                          (ev_cr_num == 4'd8 && instr_en[EN_CR8]);
        end
    end

    always_comb begin
        slot[SLOT_EXC] = mk_cand(take && ev_kind == EV_EXC && exc_bitmap[ev_vector],
                                 RS_EXCEPTION, QUAL_W'(ev_vector));
        slot[SLOT_EXT] = mk_cand(ext_irq && extint_en, RS_EXT_INT, '0);
        if (io_hit)
            slot[SLOT_INSTR] = mk_cand(1'b1, RS_IO, QUAL_W'(io_port));
        else if (cr_c.hit)
            slot[SLOT_INSTR] = cr_c;
        else
            slot[SLOT_INSTR] = instr_c;
        slot[SLOT_WIN] = mk_cand(window_en && guest_if, RS_INT_WINDOW, '0);
    end

    // fixed-priority pick, lowest slot first
    always_comb begin
        win = no_cand();
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (slot[i].hit) win = slot[i];
        end
    end

endmodule

// File: rtl/vm_exit_unit.sv
module vm_exit_unit
    import vm_exit_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              guest_mode,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_addr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [2:0]        ev_kind,
    input  logic [3:0]        ev_cls,
    input  logic [VEC_W-1:0]  ev_vector,
    input  logic [PORT_W-1:0] ev_port,
    input  logic [3:0]        ev_cr_num,
    input  logic              ev_cr_read,
    input  logic [3:0]        ev_gpr,
    input  logic              ext_irq,
    input  logic              guest_if,
    output logic              iobm_rd_en,
    output logic [PORT_W-1:0] iobm_rd_addr,
    input  logic              iobm_rd_bit,
    output logic              exit_valid,
    output logic [15:0]       exit_reason,
    output logic [QUAL_W-1:0] exit_qual,
    input  logic              exit_ack
);

    logic [N_EN-1:0]   instr_en;
    logic [31:0]       exc_bitmap;
    logic              extint_en;
    logic              window_en;
    logic              io_pend;
    logic              io_hit;
    logic [PORT_W-1:0] io_port_q;
    logic              take;
    logic              evaluate;
    exit_cand_t        win;

    assign ev_ready = !io_pend && !exit_valid;
    assign take     = ev_valid && ev_ready && guest_mode;
    assign evaluate = guest_mode && !exit_valid;

    vm_exit_ctl_regs u_ctl (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .addr       (ctl_addr),
        .wdata      (ctl_wdata),
        .instr_en   (instr_en),
        .exc_bitmap (exc_bitmap),
        .extint_en  (extint_en),
        .window_en  (window_en)
    );

    vm_exit_io_stage #(.PORT_W(PORT_W)) u_io (
        .clk     (clk),
        .rst     (rst),
        .start   (take && ev_kind == EV_IO),
        .port    (ev_port),
        .guest   (guest_mode),
        .rd_bit  (iobm_rd_bit),
        .rd_en   (iobm_rd_en),
        .rd_addr (iobm_rd_addr),
        .pend    (io_pend),
        .port_q  (io_port_q),
        .hit     (io_hit)
    );

    vm_exit_classify #(.PORT_W(PORT_W)) u_cls (
        .take       (take),
        .ev_kind    (ev_kind),
        .ev_cls     (ev_cls),
        .ev_vector  (ev_vector),
        .ev_cr_num  (ev_cr_num),
        .ev_cr_read (ev_cr_read),
        .ev_gpr     (ev_gpr),
        .ext_irq    (ext_irq),
        .guest_if   (guest_if),
        .io_hit     (io_hit),
        .io_port    (io_port_q),
        .instr_en   (instr_en),
        .exc_bitmap (exc_bitmap),
        .extint_en  (extint_en),
        .window_en  (window_en),
        .win        (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exit_valid  <= 1'b0;
            exit_reason <= '0;
            exit_qual   <= '0;
        end else if (exit_valid) begin
            if (exit_ack) exit_valid <= 1'b0;
        end else if (evaluate && win.hit) begin
            exit_valid  <= 1'b1;
            exit_reason <= win.reason;
            exit_qual   <= win.qual;
        end
    end

    p_root_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!guest_mode && !exit_valid) |=> !exit_valid)
        else $error("R1: exit raised in root mode");

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (exit_valid && !exit_ack) |=> (exit_valid && $stable(exit_reason) && $stable(exit_qual)))
        else $error("R10: pending exit changed before acknowledge");

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        (exit_valid && exit_ack) |=> !exit_valid)
        else $error("R10: exit not released after acknowledge");

    p_busy_after_lookup_r7: assert property (@(posedge clk) disable iff (rst)
        iobm_rd_en |=> !ev_ready)
        else $error("R7: ready high during bitmap lookup");

    p_cr_format_r8: assert property (@(posedge clk) disable iff (rst)
        (exit_valid && exit_reason == RS_CR_ACCESS) |-> (exit_qual[31:12] == '0 && exit_qual[7:5] == '0))
        else $error("R8: stray bits in CR qualification");

    p_exc_format_r4: assert property (@(posedge clk) disable iff (rst)
        (exit_valid && exit_reason == RS_EXCEPTION) |-> (exit_qual[31:VEC_W] == '0))
        else $error("R4: stray bits in exception qualification");

endmodule

// File: tb/vm_exit_unit_test.sv
module vm_exit_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        guest_mode = 1'b0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [2:0]  ev_kind = '0;
    logic [3:0]  ev_cls = '0;
    logic [4:0]  ev_vector = '0;
    logic [15:0] ev_port = '0;
    logic [3:0]  ev_cr_num = '0;
    logic        ev_cr_read = 1'b0;
    logic [3:0]  ev_gpr = '0;
    logic        ext_irq = 1'b0;
    logic        guest_if = 1'b0;
    logic        iobm_rd_en;
    logic [15:0] iobm_rd_addr;
    logic        iobm_rd_bit = 1'b0;
    logic        exit_valid;
    logic [15:0] exit_reason;
    logic [31:0] exit_qual;
    logic        exit_ack = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R11";

    // reference state
    bit          m_valid;
    int          m_reason;
    int unsigned m_qual;
    bit          m_pend;
    int          m_pport;
    int unsigned m_en, m_exc, m_int;

    always #4 clk = ~clk;

    vm_exit_unit uut (
        .clk(clk), .rst(rst), .guest_mode(guest_mode),
        .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
        .ev_cls(ev_cls), .ev_vector(ev_vector), .ev_port(ev_port),
        .ev_cr_num(ev_cr_num), .ev_cr_read(ev_cr_read), .ev_gpr(ev_gpr),
        .ext_irq(ext_irq), .guest_if(guest_if),
        .iobm_rd_en(iobm_rd_en), .iobm_rd_addr(iobm_rd_addr), .iobm_rd_bit(iobm_rd_bit),
        .exit_valid(exit_valid), .exit_reason(exit_reason), .exit_qual(exit_qual),
        .exit_ack(exit_ack)
    );

    function automatic bit io_map(int p);
        return ((p & 7) == 5) || (p == 'h60);
    endfunction

    // external bitmap store with one-cycle read
    always @(posedge clk) if (iobm_rd_en) iobm_rd_bit <= io_map(int'(iobm_rd_addr));

    function automatic int instr_reason(int c, output bit hit);
        hit = 1'b0;
        case (c)
            1: begin hit = 1'b1; return 10; end
            2: begin hit = 1'b1; return 31; end
            3: begin hit = 1'b1; return 32; end
            4: begin hit = m_en[0]; return 12; end
            5: begin hit = m_en[1]; return 14; end
            6: begin hit = m_en[4]; return 36; end
            7: begin hit = m_en[5]; return 15; end
            8: begin hit = m_en[6]; return 16; end
            9: begin hit = m_en[3]; return 29; end
            default: return 0;
        endcase
    endfunction

    task automatic model_edge();
        bit acc, got, h;
        int r;
        int unsigned q;
        bit nxt_pend;
        got = 0; r = 0; q = 0; nxt_pend = 0;
        if (rst) begin
            m_valid = 0; m_pend = 0; m_en = 0; m_exc = 0; m_int = 0;
            m_reason = 0; m_qual = 0;
            return;
        end
        if (m_valid) begin
            if (exit_ack) m_valid = 0;
        end else if (guest_mode) begin
            acc = ev_valid && !m_pend;
            if (acc && ev_kind == 2 && m_exc[ev_vector]) begin got = 1; r = 0; q = ev_vector; end
            if (!got && ext_irq && m_int[0]) begin got = 1; r = 1; end
            if (!got && m_pend && io_map(m_pport)) begin got = 1; r = 30; q = m_pport; end
            if (!got && acc && ev_kind == 1) begin
                r = instr_reason(int'(ev_cls), h);
                if (h) got = 1;
            end
            if (!got && acc && ev_kind == 4 &&
                ((ev_cr_num == 3 && ev_cr_read) || (ev_cr_num == 8 && m_en[2]))) begin
                got = 1; r = 28;
                q = ev_cr_num + (ev_cr_read ? 16 : 0) + (ev_gpr * 256);
            end
            if (!got && m_int[1] && guest_if) begin got = 1; r = 7; q = 0; end
            if (acc && ev_kind == 3) begin nxt_pend = 1; m_pport = ev_port; end
            if (got) begin m_valid = 1; m_reason = r; m_qual = q; end
        end
        m_pend = nxt_pend;
        if (ctl_we) begin
            case (ctl_addr)
                0: m_en = ctl_wdata & 'h7f;
                1: m_exc = ctl_wdata;
                2: m_int = ctl_wdata & 3;
                default: ;
            endcase
        end
    endtask

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("exit_valid", int'(exit_valid), int'(m_valid));
        check("ev_ready", int'(ev_ready), int'(!m_pend && !m_valid));
        if (m_valid) begin
            check("exit_reason", int'(exit_reason), m_reason);
            check("exit_qual", int'(exit_qual), int'(m_qual));
        end
    endtask

    task automatic wr(int a, int unsigned d);
        ctl_we = 1; ctl_addr = a[1:0]; ctl_wdata = d;
        step();
        ctl_we = 0;
    endtask

    task automatic ack();
        exit_ack = 1;
        step();
        exit_ack = 0;
    endtask

    task automatic ev(int kind, int cls, int vec, int port, int crn, bit rd, int gpr);
        ev_valid = 1; ev_kind = kind[2:0]; ev_cls = cls[3:0]; ev_vector = vec[4:0];
        ev_port = port[15:0]; ev_cr_num = crn[3:0]; ev_cr_read = rd; ev_gpr = gpr[3:0];
        step();
        ev_valid = 0; ev_kind = 0;
    endtask

    task automatic instr(int cls); ev(1, cls, 0, 0, 0, 0, 0); endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) step();
        if (exit_valid) ack();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 0;
        cur_req = "R11"; step();
        // R11: controls zero, so HLT is silent
        guest_mode = 1; instr(4); settle(1);

        cur_req = "R1";
        guest_mode = 0;
        wr(0, 'h7f); wr(1, 'hffff_ffff); wr(2, 3);
        guest_if = 1; ext_irq = 1;
        instr(1); ev(2, 0, 3, 0, 0, 0, 0); ev(3, 0, 0, 5, 0, 0, 0); ev(4, 0, 0, 0, 3, 1, 2);
        settle(2);
        guest_if = 0; ext_irq = 0;
        rst = 1; step(); rst = 0; step();

        cur_req = "R2"; guest_mode = 1;
        instr(1); settle(1); instr(2); settle(1); instr(3); settle(1);
        ev(4, 0, 0, 0, 3, 1, 7); settle(1);
        ev(4, 0, 0, 0, 3, 0, 7); settle(1);

        cur_req = "R3";
        for (int c = 4; c <= 9; c++) begin instr(c); settle(1); end
        ev(4, 0, 0, 0, 8, 0, 1); settle(1);
        for (int b = 0; b < 7; b++) begin
            wr(0, 1 << b);
            for (int c = 4; c <= 9; c++) begin instr(c); settle(1); end
            ev(4, 0, 0, 0, 8, 1, 2); settle(1);
        end
        instr(0); settle(1);

        cur_req = "R12";
        wr(0, 'h7f);
        for (int c = 1; c <= 9; c++) begin instr(c); settle(1); end

        cur_req = "R4";
        wr(1, 'h8000_4001);
        ev(2, 0, 0, 0, 0, 0, 0); settle(1);
        ev(2, 0, 13, 0, 0, 0, 0); settle(1);
        ev(2, 0, 14, 0, 0, 0, 0); settle(1);
        ev(2, 0, 31, 0, 0, 0, 0); settle(1);
        ev(2, 0, 30, 0, 0, 0, 0); settle(1);

        cur_req = "R5";
        ext_irq = 1; guest_if = 0; step(); ext_irq = 0; settle(1);
        wr(2, 1);
        ext_irq = 1; guest_if = 0; step(); ext_irq = 0; settle(1);

        cur_req = "R6";
        wr(2, 0); guest_if = 1; step(); step();
        wr(2, 2); step(); wr(2, 0); settle(1); guest_if = 0;

        cur_req = "R7";
        ev(3, 0, 0, 'h0060, 0, 0, 0); settle(2);
        ev(3, 0, 0, 'h0061, 0, 0, 0); settle(2);
        ev(3, 0, 0, 'h1235, 0, 0, 0);
        instr(1);    // offered while busy: dropped
        settle(2);
        ev(3, 0, 0, 'hfffd, 0, 0, 0); settle(2);

        cur_req = "R8";
        wr(0, 'h7f);
        ev(4, 0, 0, 0, 8, 0, 5); settle(1);
        ev(4, 0, 0, 0, 3, 1, 15); settle(1);
        ev(4, 0, 0, 0, 0, 0, 4); settle(1);

        cur_req = "R9";
        wr(1, 'h0000_0040); wr(2, 3); guest_if = 1; ext_irq = 1;
        ev(2, 0, 6, 0, 0, 0, 0); ack(); ack();
        instr(1); ack();
        ext_irq = 0;
        instr(1); ack(); ack();
        ev(3, 0, 0, 'h0005, 0, 0, 0); step(); ack(); ack();
        guest_if = 0; wr(2, 0); settle(1);

        cur_req = "R10";
        instr(2);
        for (int i = 0; i < 5; i++) begin instr(1); end
        ext_irq = 1; wr(2, 1); step(); ext_irq = 0; wr(2, 0);
        ack(); settle(2);

        cur_req = "R11";
        rst = 1; step(); rst = 0;
        instr(4); ev(2, 0, 6, 0, 0, 0, 0); settle(2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule